// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces one pulse-width-modulated output from an 8-bit up-counting timer. A sub-counter below the timer provides a prescale ratio of 1, 4 or 16, and a period register sets where the timer wraps. Each period lasts (period + 1) × 4 × prescale clock cycles. The output rises when a period begins and falls when a 10-bit time base reaches the duty value. The time base is the timer with two finer phase bits below it.

Software writes the duty value into a buffer: 8 upper bits in one register and the 2 lowest bits in the control register. The buffer is copied into a shadow register only when the timer rolls over, so a period never runs with a duty value that changed part way through. A separate postscaler counts rollovers and raises a one-cycle interrupt pulse on every Nth rollover, with N from 1 to 16. It has no effect on the waveform. A tristate bit decides whether the pin is driven.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, `pwm_out` is 0, `period_irq` is 0, and `pwm_oe` is 0 because the tristate bit resets to 1. The period register resets to 255, and the duty, prescale and postscale registers reset to 0.
- R2: With a nonzero duty below the full period count, successive rising edges of `pwm_out` are exactly (period + 1) × 4 × prescale clock cycles apart.
- R3: The prescale code sets the ratio: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16.
- R4: The 10-bit duty is {duty_hi_in, ctrl_duty_lo_in}, with the two control bits as the least significant bits. `pwm_out` stays high for duty × prescale clock cycles in each period.
- R5: A duty write made while a period is running does not change that period's high time. It takes effect from the next rollover.
- R6: With a latched duty of 0, `pwm_out` is never set and stays low.
- R7: With a latched duty at or above (period + 1) × 4, `pwm_out` stays high through every whole period.
- R8: Writing the control register with its enable bit at 0 forces `pwm_out` low in the cycle after the write. The output stays low and the counters hold until the block is enabled again.
- R9: `period_irq` is a one-cycle pulse issued on every (postscale + 1)th rollover. It does not change the PWM period.
- R10: `pwm_oe` is the inverse of the last tristate bit written: 0 means the pin is driven.
- R11: After enable, `pwm_out` stays low for one full period. It rises first at the first rollover, (period + 1) × 4 × prescale cycles after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_period | input | 1 | Write strobe for the period register |
| period_in | input | 8 | Period value |
| wr_duty_hi | input | 1 | Write strobe for the duty upper byte |
| duty_hi_in | input | 8 | Duty bits 9..2 |
| wr_ctrl | input | 1 | Write strobe for the control register |
| ctrl_en_in | input | 1 | PWM enable (0 clears the output) |
| ctrl_duty_lo_in | input | 2 | Duty bits 1..0 |
| wr_prescale | input | 1 | Write strobe for the prescale select |
| prescale_in | input | 2 | Prescale code |
| wr_postscale | input | 1 | Write strobe for the postscale select |
| postscale_in | input | 4 | Postscale ratio minus one |
| wr_tris | input | 1 | Write strobe for the tristate bit |
| tris_in | input | 1 | 1 = pin not driven, 0 = driven |
| pwm_out | output | 1 | PWM output latch |
| pwm_oe | output | 1 | Pin output enable |
| period_irq | output | 1 | Postscaled rollover pulse |

## Verification
The assertions assume that the period, prescale and postscale registers change only while the enable bit is 0. If the period is lowered below the current timer value during a run, the timer runs on to 255 and wraps there without a rollover, which breaks the rollover-timing relations. The bench therefore clears enable before it rewrites any of those three registers. Duty writes are the only writes it makes during a run, since double buffering exists for that case. The one-cycle interrupt check also depends on a period being at least four cycles long, and every prescale setting guarantees that.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // Largest prescale ratio is 2**PRE_LOG_MAX; sub-counter spans 4 phases of it.
    localparam int PRE_LOG_MAX = 4;
    localparam int SUB_W       = 2 + PRE_LOG_MAX;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV4   = 2'b01,
        PRE_DIV16  = 2'b10,
        PRE_DIV16B = 2'b11
    } pre_sel_e;

    typedef struct packed {
        logic       en;
        logic [1:0] duty_lo;
    } ctrl_t;

    // Last sub-count value before the timer advances.
    function automatic logic [SUB_W-1:0] sub_limit(input pre_sel_e s);
        logic [SUB_W-1:0] lim;
        case (s)
            PRE_DIV1: lim = SUB_W'(3);
            PRE_DIV4: lim = SUB_W'(15);
            default:  lim = SUB_W'(63);
        endcase
        return lim;
    endfunction

    // Two fine time-base bits taken from the top of the active sub-count range.
    function automatic logic [1:0] sub_phase(input pre_sel_e s, input logic [SUB_W-1:0] sc);
        logic [1:0] ph;
        case (s)
            PRE_DIV1: ph = sc[1:0];
            PRE_DIV4: ph = sc[3:2];
            default:  ph = sc[5:4];
        endcase
        return ph;
    endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_period,
    input  logic [TMR_W-1:0]  period_in,
    input  logic              wr_duty_hi,
    input  logic [TMR_W-1:0]  duty_hi_in,
    input  logic              wr_ctrl,
    input  ctrl_t             ctrl_in,
    input  logic              wr_prescale,
    input  logic [1:0]        prescale_in,
    input  logic              wr_postscale,
    input  logic [POST_W-1:0] postscale_in,
    input  logic              wr_tris,
    input  logic              tris_in,
    output logic [TMR_W-1:0]  period_q,
    output logic [TMR_W+1:0]  duty_buf,
    output ctrl_t             ctrl_q,
    output pre_sel_e          pre_q,
    output logic [POST_W-1:0] post_q,
    output logic              tris_q
);
    logic [TMR_W-1:0] duty_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q  <= '1;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
            pre_q     <= PRE_DIV1;
            post_q    <= '0;
            tris_q    <= 1'b1;
        end else begin
            if (wr_period)    period_q  <= period_in;
            if (wr_duty_hi)   duty_hi_q <= duty_hi_in;
            if (wr_ctrl)      ctrl_q    <= ctrl_in;
            if (wr_prescale)  pre_q     <= pre_sel_e'(prescale_in);
            if (wr_postscale) post_q    <= postscale_in;
            if (wr_tris)      tris_q    <= tris_in;
        end
    end

    assign duty_buf = {duty_hi_q, ctrl_q.duty_lo};
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  pre_sel_e         pre,
    input  logic [TMR_W-1:0] period,
    output logic             restart,
    output logic [TMR_W+1:0] tb_next
);
    logic [SUB_W-1:0] sub_q, sub_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             tick, at_end;

    assign tick    = (sub_q == sub_limit(pre));
    assign at_end  = (tmr_q == period);
    assign restart = run && tick && at_end;

    always_comb begin
        sub_d = sub_q;
        tmr_d = tmr_q;
        if (!run) begin
            sub_d = '0;
            tmr_d = '0;
        end else if (tick) begin
            sub_d = '0;
            tmr_d = at_end ? '0 : tmr_q + 1'b1;
        end else begin
            sub_d = sub_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            tmr_q <= '0;
        end else begin
            sub_q <= sub_d;
            tmr_q <= tmr_d;
        end
    end

    // Time base value that will hold after this edge.
    assign tb_next = {tmr_d, sub_phase(pre, sub_d)};
endmodule

// File: rtl/pwm_duty_unit.sv
module pwm_duty_unit #(
    parameter int TMR_W = 8,
    localparam int DUTY_W = TMR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [DUTY_W-1:0] tb_next,
    input  logic [DUTY_W-1:0] duty_buf,
    output logic [DUTY_W-1:0] shadow_q,
    output logic              out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            out_q    <= 1'b0;
        end else if (!run) begin
            out_q <= 1'b0;
        end else if (restart) begin
            shadow_q <= duty_buf;
            out_q    <= |duty_buf;
        end else if (tb_next == shadow_q) begin
            out_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [POST_W-1:0] post_sel,
    output logic              irq_q
);
    logic [POST_W-1:0] cnt_q;
    logic              hit;

    assign hit = (cnt_q == post_sel);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= restart && hit;
            if (restart) cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
    import pwm_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_period,
    input  logic [TMR_W-1:0]  period_in,
    input  logic              wr_duty_hi,
    input  logic [TMR_W-1:0]  duty_hi_in,
    input  logic              wr_ctrl,
    input  logic              ctrl_en_in,
    input  logic [1:0]        ctrl_duty_lo_in,
    input  logic              wr_prescale,
    input  logic [1:0]        prescale_in,
    input  logic              wr_postscale,
    input  logic [POST_W-1:0] postscale_in,
    input  logic              wr_tris,
    input  logic              tris_in,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic              period_irq
);
    localparam int DUTY_W = TMR_W + 2;

    ctrl_t             ctrl_in, ctrl_q;
    pre_sel_e          pre_q;
    logic [TMR_W-1:0]  period_q;
    logic [DUTY_W-1:0] duty_buf, shadow_q, tb_next;
    logic [POST_W-1:0] post_q;
    logic              tris_q, restart, out_q, run;

    assign ctrl_in = '{en: ctrl_en_in, duty_lo: ctrl_duty_lo_in};
    assign run     = ctrl_q.en;

    pwm_cfg_regs #(.TMR_W(TMR_W), .POST_W(POST_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_period(wr_period), .period_in(period_in),
        .wr_duty_hi(wr_duty_hi), .duty_hi_in(duty_hi_in),
        .wr_ctrl(wr_ctrl), .ctrl_in(ctrl_in),
        .wr_prescale(wr_prescale), .prescale_in(prescale_in),
        .wr_postscale(wr_postscale), .postscale_in(postscale_in),
        .wr_tris(wr_tris), .tris_in(tris_in),
        .period_q(period_q), .duty_buf(duty_buf), .ctrl_q(ctrl_q),
        .pre_q(pre_q), .post_q(post_q), .tris_q(tris_q)
    );

    pwm_timebase #(.TMR_W(TMR_W)) u_tb (
        .clk(clk), .rst(rst), .run(run), .pre(pre_q), .period(period_q),
        .restart(restart), .tb_next(tb_next)
    );

    pwm_duty_unit #(.TMR_W(TMR_W)) u_duty (
        .clk(clk), .rst(rst), .run(run), .restart(restart),
        .tb_next(tb_next), .duty_buf(duty_buf),
        .shadow_q(shadow_q), .out_q(out_q)
    );

    pwm_postscaler #(.POST_W(POST_W)) u_post (
        .clk(clk), .rst(rst), .run(run), .restart(restart),
        .post_sel(post_q), .irq_q(period_irq)
    );

    // A cleared enable holds the output low at once.
    assign pwm_out = out_q & run;
    assign pwm_oe  = ~tris_q;
endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_ctrl,
    input logic             ctrl_en_in,
    input logic             wr_tris,
    input logic             tris_in,
    input logic             pwm_out,
    input logic             pwm_oe,
    input logic             period_irq,
    input logic             restart,
    input logic [TMR_W+1:0] shadow
);
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ctrl_en_in) |=> !pwm_out); // R8
    AST_TRIS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_tris |=> (pwm_oe == !$past(tris_in))); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        period_irq |=> !period_irq); // R9
    AST_IRQ_ON_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        period_irq |-> $past(restart)); // R9
    AST_RISE_ON_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> $past(restart)); // R2
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (shadow == '0) |-> !pwm_out); // R6
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .ctrl_en_in(ctrl_en_in),
    .wr_tris(wr_tris), .tris_in(tris_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .period_irq(period_irq), .restart(restart), .shadow(shadow_q)
);

// File: tb/sim_pwm_shadow_gen.sv
`timescale 1ns/1ps
module sim_pwm_shadow_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_period = 0, wr_duty_hi = 0, wr_ctrl = 0, wr_prescale = 0;
    logic wr_postscale = 0, wr_tris = 0, ctrl_en_in = 0, tris_in = 1;
    logic [7:0] period_in = 0, duty_hi_in = 0;
    logic [1:0] ctrl_duty_lo_in = 0, prescale_in = 0;
    logic [3:0] postscale_in = 0;
    logic pwm_out, pwm_oe, period_irq;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    pwm_shadow_gen u0 (
        .clk(clk), .rst(rst),
        .wr_period(wr_period), .period_in(period_in),
        .wr_duty_hi(wr_duty_hi), .duty_hi_in(duty_hi_in),
        .wr_ctrl(wr_ctrl), .ctrl_en_in(ctrl_en_in), .ctrl_duty_lo_in(ctrl_duty_lo_in),
        .wr_prescale(wr_prescale), .prescale_in(prescale_in),
        .wr_postscale(wr_postscale), .postscale_in(postscale_in),
        .wr_tris(wr_tris), .tris_in(tris_in),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .period_irq(period_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: position in period counted in clocks.
    int m_pr, m_dhi, m_dlo, m_en, m_pre, m_post, m_tris;
    int k, shadow, mout, mirq, postc;
    always @(posedge clk) begin
        int ratio, plen;
        if (rst) begin
            m_pr = 255; m_dhi = 0; m_dlo = 0; m_en = 0; m_pre = 0; m_post = 0; m_tris = 1;
            k = 0; shadow = 0; mout = 0; mirq = 0; postc = 0;
        end else begin
            ratio = (m_pre == 0) ? 1 : (m_pre == 1) ? 4 : 16;
            plen  = (m_pr + 1) * 4 * ratio;
            mirq  = 0;
            if (m_en == 0) begin
                k = 0; mout = 0; postc = 0;
            end else begin
                k++;
                if (k == plen) begin
                    k = 0;
                    shadow = m_dhi * 4 + m_dlo;
                    mout = (shadow != 0);
                    if (postc == m_post) begin mirq = 1; postc = 0; end
                    else postc++;
                end else if (k / ratio == shadow) begin
                    mout = 0;
                end
            end
            if (wr_period)    m_pr   = period_in;
            if (wr_duty_hi)   m_dhi  = duty_hi_in;
            if (wr_ctrl) begin m_en  = ctrl_en_in; m_dlo = ctrl_duty_lo_in; end
            if (wr_prescale)  m_pre  = prescale_in;
            if (wr_postscale) m_post = postscale_in;
            if (wr_tris)      m_tris = tris_in;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, "pwm_out vs model", int'(pwm_out), (mout != 0 && m_en != 0) ? 1 : 0);
            chk(cur_req, "pwm_oe vs model", int'(pwm_oe), (m_tris == 0) ? 1 : 0);
            chk(cur_req, "period_irq vs model", int'(period_irq), mirq);
        end
    end

    // sel: 0 period, 1 duty hi, 2 ctrl {en,lo}, 3 prescale, 4 postscale, 5 tris
    task automatic wr(input int sel, input int val);
        case (sel)
            0: begin wr_period = 1; period_in = 8'(val); end
            1: begin wr_duty_hi = 1; duty_hi_in = 8'(val); end
            2: begin wr_ctrl = 1; ctrl_en_in = val[2]; ctrl_duty_lo_in = val[1:0]; end
            3: begin wr_prescale = 1; prescale_in = val[1:0]; end
            4: begin wr_postscale = 1; postscale_in = val[3:0]; end
            default: begin wr_tris = 1; tris_in = val[0]; end
        endcase
        @(negedge clk);
        wr_period = 0; wr_duty_hi = 0; wr_ctrl = 0; wr_prescale = 0; wr_postscale = 0; wr_tris = 0;
    endtask

    task automatic setup(input int pr, input int pre, input int dhi, input int dlo, input int post);
        wr(2, 0);
        wr(0, pr); wr(3, pre); wr(4, post); wr(1, dhi);
        wr(2, 4 + dlo);
    endtask

    task automatic measure(output int hi, output int per);
        while (pwm_out) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        hi = 0; per = 0;
        while (pwm_out) begin hi++; per++; @(negedge clk); end
        while (!pwm_out) begin per++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int hi, per, c;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "pwm_out after reset", int'(pwm_out), 0);
        chk("R1", "pwm_oe after reset", int'(pwm_oe), 0);
        chk("R1", "period_irq after reset", int'(period_irq), 0);

        // R10 tristate control
        cur_req = "R10";
        wr(5, 0); chk("R10", "pwm_oe driven", int'(pwm_oe), 1);
        wr(5, 1); chk("R10", "pwm_oe released", int'(pwm_oe), 0);
        wr(5, 0);

        // R11 first period low, then R2/R3/R4 with prescale 1
        cur_req = "R11";
        wr(0, 5); wr(1, 1);
        wr(2, 4);
        c = 0;
        while (!pwm_out) begin @(negedge clk); c++; end
        chk("R11", "cycles to first rise", c, 24);

        cur_req = "R3";
        setup(9, 0, 3, 2, 0);
        measure(hi, per);
        chk("R2", "period prescale 1", per, 40);
        chk("R4", "high time prescale 1", hi, 14);

        setup(4, 1, 1, 3, 0);
        measure(hi, per);
        chk("R3", "period prescale 4", per, 80);
        chk("R4", "high time prescale 4", hi, 28);

        setup(2, 2, 1, 1, 0);
        measure(hi, per);
        chk("R3", "period prescale 16", per, 192);
        chk("R4", "high time prescale 16", hi, 80);

        setup(1, 3, 0, 3, 0);
        measure(hi, per);
        chk("R3", "period prescale code 3", per, 128);
        chk("R4", "high time prescale code 3", hi, 48);

        // R5 duty write mid-period
        cur_req = "R5";
        setup(9, 0, 3, 2, 0);
        while (!pwm_out) @(negedge clk);
        hi = 0; c = 0;
        while (pwm_out) begin
            hi++; c++;
            if (c == 3) begin wr_duty_hi = 1; duty_hi_in = 8'd5; end
            else wr_duty_hi = 0;
            @(negedge clk);
        end
        wr_duty_hi = 0;
        chk("R5", "high time of running period", hi, 14);
        measure(hi, per);
        chk("R5", "high time after rollover", hi, 22);
        chk("R2", "period unchanged by duty write", per, 40);

        // R6 zero duty
        cur_req = "R6";
        setup(3, 0, 0, 0, 0);
        c = 0;
        repeat (100) begin @(negedge clk); if (pwm_out) c++; end
        chk("R6", "high cycles with zero duty", c, 0);

        // R7 duty at or above full period
        cur_req = "R7";
        setup(3, 0, 4, 0, 0);
        while (!pwm_out) @(negedge clk);
        c = 0;
        repeat (64) begin @(negedge clk); if (!pwm_out) c++; end
        chk("R7", "low cycles with full duty", c, 0);
        setup(3, 0, 255, 3, 0);
        while (!pwm_out) @(negedge clk);
        c = 0;
        repeat (64) begin @(negedge clk); if (!pwm_out) c++; end
        chk("R7", "low cycles with max duty", c, 0);

        // R8 clearing enable while high
        cur_req = "R8";
        wr(2, 0);
        chk("R8", "pwm_out after disable", int'(pwm_out), 0);
        c = 0;
        repeat (50) begin @(negedge clk); if (pwm_out || period_irq) c++; end
        chk("R8", "activity while disabled", c, 0);

        // R9 postscaled interrupt
        cur_req = "R9";
        setup(1, 0, 0, 3, 2);
        while (!period_irq) @(negedge clk);
        @(negedge clk);
        chk("R9", "irq width", int'(period_irq), 0);
        c = 1;
        while (!period_irq) begin @(negedge clk); c++; end
        chk("R9", "cycles between irq pulses", c, 24);
        measure(hi, per);
        chk("R9", "pwm period with postscale 3", per, 8);

        wr(2, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule